// File: doc/BRIEF.md
# Dual-Correlator Frame Sync Detector

This block watches a serial stream of bi-phase encoded chips and raises a one-cycle frame-sync strobe when it finds a programmed start identifier. The identifier is held as raw chips, not decoded bits, so it may contain encoded zeros and encoded ones alike. Two correlators, A and B, each compare the most recent chips against their own pattern of up to 16 chips. Each correlator has its own active length.

A mode field chooses how the two results combine: A alone, B alone, either of them, or A followed by B. In the chained mode, a gap setting fixes how many chips lie between the end of the A segment and the start of the B segment. No match can be declared until enough chips have arrived since reset or restart to fill the active window. After frame sync is declared it stays latched until a restart or a reset. The block advances only on cycles where the chip enable is high.

Top module: `fsync_detector`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted chip, match_a_o, match_b_o and fsync_o are all 0.
- R2: A chip is accepted only at a rising clock edge where chip_en_i is 1 and restart_i is 0. On any other cycle the outputs hold their match flags and fsync_o stays 0.
- R3: Correlator A uses length field len_a_i = n to mean n+1 active chips. Its pattern is {pat_a_hi_i, pat_a_lo_i}, where bit k is compared with the chip accepted k chips before the newest (bit 0 is the newest). It matches when all active chips are equal to their pattern bits. Pattern bits above the active length are ignored.
- R4: Correlator B follows the R3 rule with len_b_i and {pat_b_hi_i, pat_b_lo_i}, independently of A.
- R5: A correlator cannot match until at least its active length of chips has been accepted since reset or the last restart.
- R6: The mode_i encoding is: 0 declares sync on an A match, 1 on a B match, and 3 on a match of either correlator.
- R7: With mode_i = 2, sync is declared when B matches on the current chip and A matched on the chip that lies (len_b_i + 1 + gap_i) chips before it. This places gap_i chips between the two segments.
- R8: match_a_o and match_b_o are registered results for the chip accepted at the last edge. fsync_o rises in the clock cycle after the edge that accepted the completing chip and lasts exactly one cycle.
- R9: After fsync_o has pulsed, further matches produce no new pulse until restart_i or reset.
- R10: restart_i clears the chip history, the fill count, the A-match history, the match flags and the sync latch in one cycle. It takes priority over chip_en_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_i | input | 1 | Incoming chip value |
| chip_en_i | input | 1 | Chip accept enable |
| restart_i | input | 1 | Synchronous restart of the search |
| len_a_i | input | 4 | Correlator A active length minus one |
| len_b_i | input | 4 | Correlator B active length minus one |
| pat_a_hi_i | input | 8 | Correlator A pattern, older chips (bits 15:8) |
| pat_a_lo_i | input | 8 | Correlator A pattern, newer chips (bits 7:0) |
| pat_b_hi_i | input | 8 | Correlator B pattern, older chips (bits 15:8) |
| pat_b_lo_i | input | 8 | Correlator B pattern, newer chips (bits 7:0) |
| mode_i | input | 2 | Combination mode |
| gap_i | input | 4 | Chips between the A and B segments in chained mode |
| match_a_o | output | 1 | Correlator A matched on the last accepted chip |
| match_b_o | output | 1 | Correlator B matched on the last accepted chip |
| fsync_o | output | 1 | Frame-sync strobe |

## Verification
A corrupted history bit or fill count shows on the match flags one cycle after the next accepted chip. It stays visible for every chip until that bit shifts beyond the active window. A wrong A-match history tap shows only in chained mode, as a pulse that is missing or lands at the wrong spacing, and only when the B segment completes. A sync latch that does not hold shows as a second pulse on the first later match. The bench therefore compares both flags and the strobe after every chip and counts the pulses in each scenario.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic [1:0] {
    MODE_A        = 2'd0,
    MODE_B        = 2'd1,
    MODE_A_THEN_B = 2'd2,
    MODE_EITHER   = 2'd3
  } fsd_mode_e;

  localparam int unsigned NUM_CORR = 2;
endpackage

// File: rtl/fsd_delay_line.sv
module fsd_delay_line #(
  parameter int unsigned CHIPS = 16,
  parameter int unsigned CNT_W = $clog2(CHIPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             chip_i,
  output logic [CHIPS-1:0] win_o,
  output logic [CNT_W-1:0] fill_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CHIPS);

  logic [CHIPS-1:0] hist_q;
  logic [CNT_W-1:0] fill_q;

  // window as it stands after the chip being accepted now
  assign win_o  = adv_i ? {hist_q[CHIPS-2:0], chip_i} : hist_q;
  assign fill_o = (adv_i && fill_q != FULL) ? fill_q + 1'b1 : fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (adv_i) begin
      hist_q <= win_o;
      fill_q <= fill_o;
    end
  end
endmodule

// File: rtl/fsd_correlator.sv
module fsd_correlator #(
  parameter int unsigned CHIPS = 16,
  parameter int unsigned LEN_W = $clog2(CHIPS),
  parameter int unsigned CNT_W = $clog2(CHIPS + 1)
) (
  input  logic [CHIPS-1:0] win_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CHIPS-1:0] pat_i,
  output logic             hit_o
);
  logic [CHIPS-1:0] mask;
  logic [CHIPS-1:0] diff;
  logic             filled;

  for (genvar k = 0; k < CHIPS; k++) begin : g_mask
    assign mask[k] = (LEN_W'(k) <= len_i);
  end

  assign diff   = (win_i ^ pat_i) & mask;
  assign filled = fill_i > CNT_W'(len_i);
  assign hit_o  = filled && (diff == '0);
endmodule

// File: rtl/fsd_sync_ctrl.sv
module fsd_sync_ctrl
  import fsd_pkg::*;
#(
  parameter int unsigned CHIPS = 16,
  parameter int unsigned LEN_W = $clog2(CHIPS),
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             hit_a_i,
  input  logic             hit_b_i,
  input  fsd_mode_e        mode_i,
  input  logic [LEN_W-1:0] len_b_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             match_a_o,
  output logic             match_b_o,
  output logic             fsync_o
);
  localparam int unsigned AH    = CHIPS + (1 << GAP_W);
  localparam int unsigned IDX_W = $clog2(AH);

  // a_hist_q[k]: A matched k+1 chips before the chip now arriving
  logic [AH-1:0]    a_hist_q;
  logic [IDX_W-1:0] tap;
  logic             a_prior;
  logic             cand;
  logic             fire;
  logic             done_q;
  logic             match_a_q, match_b_q, fsync_q;

  assign tap     = IDX_W'(len_b_i) + IDX_W'(gap_i);
  assign a_prior = a_hist_q[tap];

  always_comb begin
    unique case (mode_i)
      MODE_A:        cand = hit_a_i;
      MODE_B:        cand = hit_b_i;
      MODE_A_THEN_B: cand = hit_b_i && a_prior;
      MODE_EITHER:   cand = hit_a_i || hit_b_i;
      default:       cand = 1'b0;
    endcase
  end

  assign fire = adv_i && cand && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_hist_q  <= '0;
      done_q    <= 1'b0;
      match_a_q <= 1'b0;
      match_b_q <= 1'b0;
      fsync_q   <= 1'b0;
    end else if (clr_i) begin
      a_hist_q  <= '0;
      done_q    <= 1'b0;
      match_a_q <= 1'b0;
      match_b_q <= 1'b0;
      fsync_q   <= 1'b0;
    end else begin
      fsync_q <= fire;
      if (fire) done_q <= 1'b1;
      if (adv_i) begin
        a_hist_q  <= {a_hist_q[AH-2:0], hit_a_i};
        match_a_q <= hit_a_i;
        match_b_q <= hit_b_i;
      end
    end
  end

  assign match_a_o = match_a_q;
  assign match_b_o = match_b_q;
  assign fsync_o   = fsync_q;
endmodule

// File: rtl/fsync_detector.sv
module fsync_detector
  import fsd_pkg::*;
#(
  parameter int unsigned CHIPS = 16,
  parameter int unsigned GAP_W = 4,
  parameter int unsigned LEN_W = $clog2(CHIPS),
  parameter int unsigned HALF  = CHIPS / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chip_i,
  input  logic             chip_en_i,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] len_a_i,
  input  logic [LEN_W-1:0] len_b_i,
  input  logic [HALF-1:0]  pat_a_hi_i,
  input  logic [HALF-1:0]  pat_a_lo_i,
  input  logic [HALF-1:0]  pat_b_hi_i,
  input  logic [HALF-1:0]  pat_b_lo_i,
  input  logic [1:0]       mode_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             match_a_o,
  output logic             match_b_o,
  output logic             fsync_o
);
  localparam int unsigned CNT_W = $clog2(CHIPS + 1);

  logic                              adv;
  logic [CHIPS-1:0]                  win;
  logic [CNT_W-1:0]                  fill;
  logic [NUM_CORR-1:0][CHIPS-1:0]    pat;
  logic [NUM_CORR-1:0][LEN_W-1:0]    len;
  logic [NUM_CORR-1:0]               hit;

  assign adv    = chip_en_i && !restart_i;
  assign pat[0] = {pat_a_hi_i, pat_a_lo_i};
  assign pat[1] = {pat_b_hi_i, pat_b_lo_i};
  assign len[0] = len_a_i;
  assign len[1] = len_b_i;

  fsd_delay_line #(.CHIPS(CHIPS), .CNT_W(CNT_W)) u_dline (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart_i),
    .adv_i  (adv),
    .chip_i (chip_i),
    .win_o  (win),
    .fill_o (fill)
  );

  for (genvar g = 0; g < NUM_CORR; g++) begin : g_corr
    fsd_correlator #(.CHIPS(CHIPS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_corr (
      .win_i  (win),
      .fill_i (fill),
      .len_i  (len[g]),
      .pat_i  (pat[g]),
      .hit_o  (hit[g])
    );
  end

  fsd_sync_ctrl #(.CHIPS(CHIPS), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (restart_i),
    .adv_i     (adv),
    .hit_a_i   (hit[0]),
    .hit_b_i   (hit[1]),
    .mode_i    (fsd_mode_e'(mode_i)),
    .len_b_i   (len_b_i),
    .gap_i     (gap_i),
    .match_a_o (match_a_o),
    .match_b_o (match_b_o),
    .fsync_o   (fsync_o)
  );
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int unsigned CHIPS = 16,
  parameter int unsigned LEN_W = $clog2(CHIPS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_en_i,
  input logic             restart_i,
  input logic [LEN_W-1:0] len_a_i,
  input logic [LEN_W-1:0] len_b_i,
  input logic             match_a_o,
  input logic             match_b_o,
  input logic             fsync_o
);
  logic [5:0] acc_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else if (restart_i) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (chip_en_i && acc_q != 6'h3f) acc_q <= acc_q + 1'b1;
      if (fsync_o) seen_q <= 1'b1;
    end
  end

  AST_FSYNC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |=> !fsync_o); // R8

  AST_FSYNC_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> !seen_q); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_en_i && !restart_i) |=> (!fsync_o && $stable(match_a_o) && $stable(match_b_o))); // R2

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!fsync_o && !match_a_o && !match_b_o)); // R10

  AST_FSYNC_HAS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> (match_a_o || match_b_o)); // R6

  AST_FILL_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(chip_en_i && !restart_i) && match_a_o) |-> (acc_q > 6'($past(len_a_i)))); // R5

  AST_FILL_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(chip_en_i && !restart_i) && match_b_o) |-> (acc_q > 6'($past(len_b_i)))); // R5
endmodule

bind fsync_detector fsd_checker #(.CHIPS(CHIPS), .LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chip_en_i (chip_en_i),
  .restart_i (restart_i),
  .len_a_i   (len_a_i),
  .len_b_i   (len_b_i),
  .match_a_o (match_a_o),
  .match_b_o (match_b_o),
  .fsync_o   (fsync_o)
);

// File: tb/fsync_detector_tb_top.sv
`timescale 1ns/1ps
module fsync_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chip_i = 1'b0, chip_en_i = 1'b0, restart_i = 1'b0;
  logic [3:0] len_a = '0, len_b = '0, gap = '0;
  logic [15:0] pat_a = '0, pat_b = '0;
  logic [1:0] mode = '0;
  logic       match_a_o, match_b_o, fsync_o;

  int n_tests = 0, n_fail = 0, n_sync = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference state
  logic [15:0] m_hist;
  int          m_fill;
  logic [63:0] m_ahist;
  bit          m_done, e_ma, e_mb, e_fs;

  always #2.5 clk = ~clk;

  fsync_detector dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .chip_i(chip_i), .chip_en_i(chip_en_i),
    .restart_i(restart_i), .len_a_i(len_a), .len_b_i(len_b),
    .pat_a_hi_i(pat_a[15:8]), .pat_a_lo_i(pat_a[7:0]),
    .pat_b_hi_i(pat_b[15:8]), .pat_b_lo_i(pat_b[7:0]),
    .mode_i(mode), .gap_i(gap),
    .match_a_o(match_a_o), .match_b_o(match_b_o), .fsync_o(fsync_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit corr(input logic [15:0] h, input int fill, input int l, input logic [15:0] p);
    logic [15:0] mk = 16'((32'd1 << (l + 1)) - 1);
    return (fill > l) && (((h ^ p) & mk) == 16'h0);
  endfunction

  function automatic void model_clear();
    m_hist = '0; m_fill = 0; m_ahist = '0; m_done = 0;
    e_ma = 0; e_mb = 0; e_fs = 0;
  endfunction

  function automatic void model_step(input bit c, input bit en, input bit rs);
    bit ha, hb, cand, prior;
    e_fs = 0;
    if (rs) begin
      model_clear();
    end else if (en) begin
      m_hist = {m_hist[14:0], c};
      if (m_fill < 16) m_fill++;
      ha = corr(m_hist, m_fill, int'(len_a), pat_a);
      hb = corr(m_hist, m_fill, int'(len_b), pat_b);
      // chained: A completed len_b+1+gap chips before the current chip
      prior = m_ahist[int'(len_b) + int'(gap)];
      case (mode)
        2'd0: cand = ha;
        2'd1: cand = hb;
        2'd2: cand = hb && prior;
        default: cand = ha || hb;
      endcase
      e_fs = cand && !m_done;
      if (e_fs) m_done = 1;
      m_ahist = {m_ahist[62:0], ha};
      e_ma = ha; e_mb = hb;
    end
  endfunction

  task automatic step(input bit c, input bit en, input bit rs, input string req);
    @(negedge clk);
    chip_i = c; chip_en_i = en; restart_i = rs;
    model_step(c, en, rs);
    @(negedge clk);
    check(req, "match_a_o", match_a_o, e_ma);
    check(req, "match_b_o", match_b_o, e_mb);
    check(req, "fsync_o", fsync_o, e_fs);
    if (fsync_o) n_sync++;
    chip_en_i = 0; restart_i = 0;
    @(negedge clk);
    // idle cycle: flags hold, no strobe (R2, R8)
    check("R2", "idle match_a_o", match_a_o, e_ma);
    check("R8", "idle fsync_o", fsync_o, 1'b0);
  endtask

  task automatic rnd_chip(input string req);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    step(lfsr[0], 1'b1, 1'b0, req);
  endtask

  task automatic send_pat(input logic [15:0] p, input int l, input string req);
    for (int k = l; k >= 0; k--) step(p[k], 1'b1, 1'b0, req);
  endtask

  task automatic restart(input string req);
    step(1'b0, 1'b0, 1'b1, req);
    n_sync = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    model_clear();
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check("R1", "reset match_a_o", match_a_o, 1'b0);
    check("R1", "reset match_b_o", match_b_o, 1'b0);
    check("R1", "reset fsync_o", fsync_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "post-reset fsync_o", fsync_o, 1'b0);

    // R5: all-zero pattern of 16 chips on cleared history needs a full window
    mode = 2'd0; len_a = 4'd15; pat_a = 16'h0000; len_b = 4'd15; pat_b = 16'hFFFF;
    for (int k = 0; k < 16; k++) step(1'b0, 1'b1, 1'b0, "R5");
    check_int("R5", "sync count after fill", n_sync, 1);

    // R3: sweep A lengths with run-in and unused upper pattern bits set to noise
    for (int l = 0; l < 16; l++) begin
      restart("R10");
      mode = 2'd0; len_a = 4'(l); pat_a = 16'h5A3C ^ 16'(l * 16'h1111);
      for (int k = 0; k < 8; k++) rnd_chip("R3");
      send_pat(pat_a, l, "R3");
      check_int("R3", "A sweep sync count", n_sync, 1);
      check("R3", "A match flag at end", match_a_o, 1'b1);
      send_pat(pat_a, l, "R9"); // R9: repeated identifier, no new pulse
      check_int("R9", "latched sync count", n_sync, 1);
    end

    // R4: B sweep, A programmed to something that differs
    for (int l = 0; l < 16; l++) begin
      restart("R10");
      mode = 2'd1; len_b = 4'(l); pat_b = 16'hC3A9 + 16'(l * 16'h0B07);
      len_a = 4'd15; pat_a = ~pat_b;
      for (int k = 0; k < 8; k++) rnd_chip("R4");
      send_pat(pat_b, l, "R4");
      check_int("R4", "B sweep sync count", n_sync, 1);
    end

    // R7: chained mode across B lengths and every gap
    foreach (pat_b[i]) begin end
    for (int lb = 0; lb < 16; lb += 5) begin
      for (int g = 0; g < 16; g++) begin
        restart("R10");
        mode = 2'd2; len_a = 4'd7; pat_a = 16'h00B4; len_b = 4'(lb);
        pat_b = 16'h9D62 ^ 16'(g); gap = 4'(g);
        for (int k = 0; k < 8; k++) rnd_chip("R7");
        send_pat(pat_a, 7, "R7");
        for (int k = 0; k < g; k++) rnd_chip("R7");
        send_pat(pat_b, lb, "R7");
        check_int("R7", "chained sync count", n_sync, 1);
      end
    end

    // R7: wrong spacing (one extra chip) must not use the tap
    restart("R10");
    mode = 2'd2; len_a = 4'd7; pat_a = 16'h00B4; len_b = 4'd7; pat_b = 16'h004B; gap = 4'd2;
    send_pat(pat_a, 7, "R7");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, "R7");
    send_pat(pat_b, 7, "R7");
    check_int("R7", "misspaced chained sync count", n_sync, 0);

    // R6: either mode, random stream
    restart("R10");
    mode = 2'd3; len_a = 4'd3; pat_a = 16'h000A; len_b = 4'd4; pat_b = 16'h0013;
    for (int k = 0; k < 200; k++) rnd_chip("R6");
    restart("R10");
    send_pat(16'h0013, 4, "R6");
    check_int("R6", "either mode via B", n_sync, 1);

    // R2: chip_en low with changing chip_i
    restart("R10");
    mode = 2'd0; len_a = 4'd5; pat_a = 16'h002D;
    for (int k = 5; k >= 0; k--) begin
      step(~pat_a[k], 1'b0, 1'b0, "R2");
      step(pat_a[k], 1'b1, 1'b0, "R2");
    end
    check_int("R2", "sync with gated chips", n_sync, 1);

    // R10: restart with chip_en high drops the chip and clears state
    send_pat(pat_a, 4, "R10");
    step(pat_a[0], 1'b1, 1'b1, "R10");
    n_sync = 0;
    send_pat(pat_a, 5, "R10");
    check_int("R10", "sync after restart", n_sync, 1);

    // R8: long random run in every mode
    for (int m = 0; m < 4; m++) begin
      restart("R10");
      mode = 2'(m); len_a = 4'd2; pat_a = 16'h0005; len_b = 4'd2; pat_b = 16'h0002; gap = 4'd1;
      for (int k = 0; k < 150; k++) rnd_chip("R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule